// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is the control side of one DMA channel. It runs a scatter-gather sequence on its own. The channel holds a bank of configuration registers. It refills some of them from a chain of descriptors that sit in memory, then hands each transfer to an external data mover through a start/done handshake. After each transfer it follows the descriptor's link to the next one, with no processor action in between.

Software sets up the channel through a small register port: a control word, the pointer to the first descriptor, and the channel registers. It then pulses `start_i`.

- **Non-list mode:** one transfer runs.
- **List mode, deferred first load:** the first transfer runs with the values already loaded, and only then is the first descriptor fetched.
- **List mode, fast first load:** the first descriptor is fetched before any transfer.

A descriptor can hold the channel in a paused state until `resume_i`. A one-cycle interrupt marks the end of the whole chain.

Descriptor layout, as sequential 32-bit reads from the descriptor address:

| Word | Content |
|------|---------|
| 0 | Next-descriptor pointer |
| 1 | Flag word |
| 2 and up | Payload words, which land in channel registers 0, 1, 2, … in order |

Channel register 0 is the source address. Channel register 1 is the destination address. Registers 2 and 3 hold the element count and the frame count.

Top module: `lldma_chan`

## Requirements
- R1: After reset the status is idle (0), `irq_o`, `mem_req_o` and `xfer_start_o` are low, channel register 2 reads 0x00FFFFFF, register 3 reads 0x0000FFFF, and the other channel registers read 0.
- R2: With control bit 8 (list) clear, `start_i` runs exactly one transfer using the current source and destination registers, issues no memory read, and then raises the interrupt.
- R3: In list mode with control bit 10 (fast) set, the first descriptor is fetched from the first-descriptor pointer before any transfer. A descriptor at address A is read as single-word requests at A, A+4, A+8, …, for 2 + N words, and the transfer after the load uses the loaded addresses.
- R4: In list mode with the fast bit clear, the first transfer uses the register values present at start, and only after it completes is the first descriptor fetched.
- R5: After each transfer in list mode the channel follows the loaded descriptor's next pointer. A pointer of 0xFFFFFFFC ends the chain. `irq_o` is a single-cycle pulse raised only after the last transfer, and a fast start whose first pointer is 0xFFFFFFFC finishes with no transfer.
- R6: Control bits 5:4 select the payload length. 01 gives 8 words (registers 0..7), 10 gives 4 words (registers 0..3), 11 gives 2 words (registers 0..1), and 00 gives none. Registers beyond the payload keep their values.
- R7: Register 0 (source) is loaded only when flag bit 24 and control bit 2 are both set. Register 1 (destination) is loaded only when flag bit 26 and control bit 0 are both set. Otherwise each keeps its value.
- R8: With control bit 7 (pause enable) set, a descriptor whose flag bit 0 is set leaves the channel paused (status 3) with no transfer started until `resume_i`. With control bit 7 clear the flag has no effect, and `resume_i` outside the paused state has no effect.
- R9: `start_i` is accepted only when the status is idle (0) or done (4).
- R10: Register writes are ignored unless the status is idle or done.
- R11: Status codes read at `status_o` and at register address 2: 0 idle, 1 fetching, 2 transferring, 3 paused, 4 done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address: 0 control, 1 first pointer, 2 status (read only), 8..15 channel registers 0..7 |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| start_i | input | 1 | Start command pulse |
| resume_i | input | 1 | Resume command pulse |
| status_o | output | 3 | Channel status code |
| irq_o | output | 1 | Chain-complete interrupt pulse |
| mem_req_o | output | 1 | One-cycle word read request |
| mem_addr_o | output | 32 | Read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| xfer_start_o | output | 1 | One-cycle transfer start to the data mover |
| xfer_done_i | input | 1 | Transfer complete from the data mover |
| xfer_src_o | output | 32 | Source address of the transfer |
| xfer_dst_o | output | 32 | Destination address of the transfer |

## Verification

**Single-step responses.**
- A start, resume or fetch-complete takes effect on `status_o` one clock after the edge that samples it.
- `xfer_start_o` is high in the first cycle of the transferring state.
- Each read request is answered by the bench memory a programmable number of cycles later.
- The interrupt rises one cycle after the edge that samples the final done or the terminating pointer.

**How the bench observes them.**
- The bench drives inputs and samples outputs one nanosecond after the rising edge.
- Fixed-latency results are checked after a known number of edges.
- Chain results depend on the memory and mover latencies. For these, the bench counts interrupts, reads and transfers in monitor loops, and checks the logs once the interrupt counter moves.
- Pause behaviour is checked by holding for a fixed window and confirming that no transfer starts.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_XFER  = 3'd2,
    ST_PAUSE = 3'd3,
    ST_DONE  = 3'd4
  } chan_st_e;

  localparam logic [31:0] LIST_END = 32'hFFFF_FFFC;

  // control word bits
  localparam int CB_DST   = 0;
  localparam int CB_SRC   = 2;
  localparam int CB_TLO   = 4;
  localparam int CB_PAUSE = 7;
  localparam int CB_LIST  = 8;
  localparam int CB_FAST  = 10;

  // descriptor flag word bits
  localparam int FB_PAUSE = 0;
  localparam int FB_SRC   = 24;
  localparam int FB_DST   = 26;

  function automatic logic [3:0] payload_words(input logic [1:0] t);
    case (t)
      2'b01:   return 4'd8;
      2'b10:   return 4'd4;
      2'b11:   return 4'd2;
      default: return 4'd0;
    endcase
  endfunction

  // unset markers for the count registers
  function automatic logic [31:0] reg_rst_val(input int g);
    if (g == 2) return 32'h00FF_FFFF;
    if (g == 3) return 32'h0000_FFFF;
    return 32'h0;
  endfunction
endpackage

// File: rtl/lldma_fetch.sv
module lldma_fetch #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [DW-1:0] base_i,
  input  logic [CW-1:0] nwords_i,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          wd_valid_o,
  output logic [CW-1:0] wd_idx_o,
  output logic [DW-1:0] wd_data_o,
  output logic          done_o
);
  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  logic          busy_q, wait_q;
  logic [CW-1:0] idx_q, last_q;
  logic [DW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wait_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      addr_q <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        wait_q <= 1'b0;
        idx_q  <= '0;
        last_q <= nwords_i - CW'(1);
        addr_q <= base_i;
      end
    end else if (!wait_q) begin
      wait_q <= 1'b1;
    end else if (mem_rvalid_i) begin
      wait_q <= 1'b0;
      idx_q  <= idx_q + CW'(1);
      addr_q <= addr_q + STEP;
      if (idx_q == last_q) busy_q <= 1'b0;
    end
  end

  assign mem_req_o  = busy_q & ~wait_q;
  assign mem_addr_o = addr_q;
  assign wd_valid_o = busy_q & wait_q & mem_rvalid_i;
  assign wd_idx_o   = idx_q;
  assign wd_data_o  = mem_rdata_i;
  assign done_o     = wd_valid_o & (idx_q == last_q);

  p_req_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_valid_o && !done_o) |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + STEP));
endmodule

// File: rtl/lldma_regs.sv
module lldma_regs
  import lldma_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int CW   = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sw_we_i,
  input  logic [$clog2(NREG)-1:0]    sw_idx_i,
  input  logic [DW-1:0]              sw_data_i,
  input  logic                       ld_valid_i,
  input  logic [CW-1:0]              ld_idx_i,
  input  logic [DW-1:0]              ld_data_i,
  input  logic                       src_en_i,
  input  logic                       dst_en_i,
  output logic [NREG-1:0][DW-1:0]    regs_o,
  output logic [DW-1:0]              next_ptr_o,
  output logic                       pause_flag_o
);
  localparam int IW = $clog2(NREG);

  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] next_q;
  logic          f_pause_q, f_src_q, f_dst_q;
  logic          pay_c;
  logic [CW-1:0] slot_c;

  assign pay_c  = ld_valid_i && (ld_idx_i >= CW'(2));
  assign slot_c = ld_idx_i - CW'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q    <= '0;
      f_pause_q <= 1'b0;
      f_src_q   <= 1'b0;
      f_dst_q   <= 1'b0;
    end else if (ld_valid_i && ld_idx_i == CW'(0)) begin
      next_q <= ld_data_i;
    end else if (ld_valid_i && ld_idx_i == CW'(1)) begin
      f_pause_q <= ld_data_i[FB_PAUSE];
      f_src_q   <= ld_data_i[FB_SRC];
      f_dst_q   <= ld_data_i[FB_DST];
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic gate, ld_hit;
    if (g == 0) begin : g_src
      assign gate = f_src_q & src_en_i;
    end else if (g == 1) begin : g_dst
      assign gate = f_dst_q & dst_en_i;
    end else begin : g_cfg
      assign gate = 1'b1;
    end
    assign ld_hit = pay_c && (slot_c == CW'(g)) && gate;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    regs_q[g] <= DW'(reg_rst_val(g));
      else if (ld_hit)                                regs_q[g] <= ld_data_i;
      else if (sw_we_i && sw_idx_i == IW'(g))         regs_q[g] <= sw_data_i;
    end
    assign regs_o[g] = regs_q[g];
  end

  assign next_ptr_o   = next_q;
  assign pause_flag_o = f_pause_q;

  p_hdr_keeps_regs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_idx_i < CW'(2) && !sw_we_i) |=> $stable(regs_o));
  p_src_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_idx_i == CW'(2) && !(f_src_q && src_en_i) && !sw_we_i)
      |=> $stable(regs_o[0]));
endmodule

// File: rtl/lldma_chan.sv
module lldma_chan
  import lldma_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          start_i,
  input  logic          resume_i,
  output logic [2:0]    status_o,
  output logic          irq_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          xfer_start_o,
  input  logic          xfer_done_i,
  output logic [DW-1:0] xfer_src_o,
  output logic [DW-1:0] xfer_dst_o
);
  localparam int CW = 4;
  localparam int IW = $clog2(NREG);

  chan_st_e st_q, st_d;
  logic [DW-1:0] ctrl_q, first_q, fptr_q, tgt_c, next_ptr;
  logic          loaded_q, xstart_q, irq_q, idle_c, pause_c, pause_flag;
  logic          list_c, fast_c, pen_c;
  logic [CW-1:0] nwords_c, f_idx;
  logic          f_valid, f_done;
  logic [DW-1:0] f_data;
  logic [NREG-1:0][DW-1:0] regs;
  logic          sw_chan_we;

  assign idle_c   = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign list_c   = ctrl_q[CB_LIST];
  assign fast_c   = ctrl_q[CB_FAST];
  assign pen_c    = ctrl_q[CB_PAUSE];
  assign nwords_c = CW'(4'd2 + payload_words(ctrl_q[CB_TLO+1:CB_TLO]));
  assign tgt_c    = loaded_q ? next_ptr : fptr_q;
  // pause flag may arrive in the completing word when there is no payload
  assign pause_c  = (f_idx == CW'(1)) ? f_data[FB_PAUSE] : pause_flag;
  assign sw_chan_we = reg_we_i && idle_c && reg_addr_i[3];

  lldma_fetch #(.DW(DW), .CW(CW)) u_fetch (
    .clk_i, .rst_ni,
    .go_i        (st_q == ST_FETCH),
    .base_i      (fptr_q),
    .nwords_i    (nwords_c),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .wd_valid_o  (f_valid),
    .wd_idx_o    (f_idx),
    .wd_data_o   (f_data),
    .done_o      (f_done)
  );

  lldma_regs #(.DW(DW), .NREG(NREG), .CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .sw_we_i      (sw_chan_we),
    .sw_idx_i     (reg_addr_i[IW-1:0]),
    .sw_data_i    (reg_wdata_i),
    .ld_valid_i   (f_valid),
    .ld_idx_i     (f_idx),
    .ld_data_i    (f_data),
    .src_en_i     (ctrl_q[CB_SRC]),
    .dst_en_i     (ctrl_q[CB_DST]),
    .regs_o       (regs),
    .next_ptr_o   (next_ptr),
    .pause_flag_o (pause_flag)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE:
        if (start_i) begin
          if (list_c && fast_c) st_d = (first_q == LIST_END) ? ST_DONE : ST_FETCH;
          else                  st_d = ST_XFER;
        end
      ST_FETCH: if (f_done) st_d = (pen_c && pause_c) ? ST_PAUSE : ST_XFER;
      ST_PAUSE: if (resume_i) st_d = ST_XFER;
      ST_XFER:
        if (xfer_done_i) begin
          if (!list_c)                st_d = ST_DONE;
          else if (tgt_c == LIST_END) st_d = ST_DONE;
          else                        st_d = ST_FETCH;
        end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ctrl_q   <= '0;
      first_q  <= '0;
      fptr_q   <= '0;
      loaded_q <= 1'b0;
      xstart_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      xstart_q <= (st_d == ST_XFER) && (st_q != ST_XFER);
      irq_q    <= (st_d == ST_DONE) && ((st_q != ST_DONE) || start_i);
      if (reg_we_i && idle_c && reg_addr_i == 4'd0) ctrl_q  <= reg_wdata_i;
      if (reg_we_i && idle_c && reg_addr_i == 4'd1) first_q <= reg_wdata_i;
      if (idle_c && start_i) begin
        fptr_q   <= first_q;
        loaded_q <= 1'b0;
      end
      if (st_q == ST_FETCH && f_done) loaded_q <= 1'b1;
      if (st_q == ST_XFER && xfer_done_i && list_c) fptr_q <= tgt_c;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[3])             reg_rdata_o = regs[reg_addr_i[IW-1:0]];
    else if (reg_addr_i == 4'd0)   reg_rdata_o = ctrl_q;
    else if (reg_addr_i == 4'd1)   reg_rdata_o = first_q;
    else if (reg_addr_i == 4'd2)   reg_rdata_o = DW'(st_q);
  end

  assign status_o     = st_q;
  assign irq_o        = irq_q;
  assign xfer_start_o = xstart_q;
  assign xfer_src_o   = regs[0];
  assign xfer_dst_o   = regs[1];

  p_irq_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_pause_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PAUSE && !resume_i) |=> (st_q == ST_PAUSE && !xfer_start_o));
  p_cfg_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !idle_c) |=> ($stable(ctrl_q) && $stable(first_q)));
  p_fetch_list_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FETCH) |-> ctrl_q[CB_LIST]);
  p_xstart_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_start_o |-> (st_q == ST_XFER));
  p_start_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_q == ST_XFER && !xfer_done_i) |=> (st_q == ST_XFER));
endmodule

// File: tb/sim_lldma_chan.sv
`timescale 1ns/1ps
module sim_lldma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        start = 1'b0, resume = 1'b0;
  logic [2:0]  status;
  logic        irq;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        xstart;
  logic        xdone = 1'b0;
  logic [31:0] xsrc_o, xdst_o;

  always #2 clk = ~clk;

  lldma_chan u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .start_i(start), .resume_i(resume), .status_o(status), .irq_o(irq),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .xfer_start_o(xstart), .xfer_done_i(xdone), .xfer_src_o(xsrc_o), .xfer_dst_o(xdst_o)
  );

  localparam logic [31:0] END_PTR = 32'hFFFF_FFFC;
  localparam logic [31:0] C_DST = 32'h1, C_SRC = 32'h4, C_PEN = 32'h80,
                          C_LIST = 32'h100, C_FAST = 32'h400;
  localparam logic [31:0] F_PAUSE = 32'h1, F_SRC = 32'h0100_0000, F_DST = 32'h0400_0000;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [31:0] mem [0:255];
  int nreads = 0, nx = 0, irq_cnt = 0;
  logic [31:0] raddr [0:127];
  logic [31:0] xs [0:31];
  logic [31:0] xd [0:31];
  int mem_lat = 1, mov_lat = 3;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory responder
  initial begin
    int cd = 0;
    logic [31:0] a = '0;
    forever begin
      @(posedge clk); #1;
      mem_rvalid = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin mem_rvalid = 1'b1; mem_rdata = mem[a[9:2]]; end
      end
      if (mem_req) begin
        a = mem_addr;
        if (nreads < 128) raddr[nreads] = a;
        nreads++;
        cd = mem_lat;
      end
    end
  end

  // data mover model
  initial begin
    int cd = 0;
    forever begin
      @(posedge clk); #1;
      xdone = 1'b0;
      if (cd > 0) begin
        cd--;
        if (cd == 0) xdone = 1'b1;
      end
      if (xstart) begin
        if (nx < 32) begin xs[nx] = xsrc_o; xd[nx] = xdst_o; end
        nx++;
        cd = mov_lat;
      end
    end
  end

  initial forever begin
    @(posedge clk); #1;
    if (irq) irq_cnt++;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #0.5;
    d = reg_rdata;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
  endtask

  task automatic pulse_resume();
    @(posedge clk); #1; resume = 1'b1;
    @(posedge clk); #1; resume = 1'b0;
  endtask

  task automatic clear_logs();
    nreads = 0; nx = 0;
  endtask

  task automatic wait_irq(input string req, input int n0, output int nx_at);
    int k = 0;
    while (irq_cnt == n0 && k < 3000) begin @(posedge clk); #2; k++; end
    nx_at = nx;
    chk({req, " irq seen"}, irq_cnt, n0 + 1);
  endtask

  task automatic put_desc(input int b, input logic [31:0] nxt, input logic [31:0] fl,
                          input int pw, input logic [31:0] seed);
    mem[b/4]   = nxt;
    mem[b/4+1] = fl;
    for (int i = 0; i < pw; i++) mem[b/4+2+i] = seed + 32'(i);
  endtask

  initial begin
    logic [31:0] v;
    int n0, nxa;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 status", 32'(status), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 xfer_start", 32'(xstart), 32'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    rd(4'd2, v);  chk("R11 status reg idle", v, 32'd0);
    rd(4'd10, v); chk("R1 elem count marker", v, 32'h00FF_FFFF);
    rd(4'd11, v); chk("R1 frame count marker", v, 32'h0000_FFFF);
    rd(4'd8, v);  chk("R1 src reset", v, 32'd0);

    // R2 non-list single transfer
    wr(4'd8, 32'h1000); wr(4'd9, 32'h2000); wr(4'd0, C_SRC | C_DST);
    clear_logs(); mov_lat = 12; n0 = irq_cnt;
    pulse_start();
    repeat (3) @(posedge clk); #2;
    chk("R11 status transferring", 32'(status), 32'd2);
    wait_irq("R2", n0, nxa);
    chk("R2 one transfer", nx, 1);
    chk("R2 src", xs[0], 32'h1000);
    chk("R2 dst", xd[0], 32'h2000);
    chk("R2 no reads", nreads, 0);
    chk("R11 status done", 32'(status), 32'd4);
    mov_lat = 3;

    // R3/R6/R7 sweep: type x flag valid x control valid
    for (int t = 0; t < 4; t++)
      for (int fv = 0; fv < 4; fv++)
        for (int cv = 0; cv < 4; cv++) begin
          int pw;
          logic [31:0] seed, fl, ct, e;
          pw = (t == 1) ? 8 : (t == 2) ? 4 : (t == 3) ? 2 : 0;
          seed = 32'h5000_0000 + 32'(t * 256 + fv * 16 + cv);
          fl = (fv[0] ? F_SRC : 0) | (fv[1] ? F_DST : 0);
          ct = C_LIST | C_FAST | (32'(t) << 4) | (cv[0] ? C_SRC : 0) | (cv[1] ? C_DST : 0);
          for (int k = 0; k < 8; k++) wr(4'(8 + k), 32'hA000_0000 + 32'(k));
          wr(4'd0, ct); wr(4'd1, 32'h100);
          put_desc(32'h100, END_PTR, fl, pw, seed);
          clear_logs(); n0 = irq_cnt;
          pulse_start();
          wait_irq("R3 sweep", n0, nxa);
          chk("R3 one transfer", nx, 1);
          chk("R3 read count", nreads, 2 + pw);
          for (int i = 0; i < 2 + pw; i++) chk("R3 read addr", raddr[i], 32'h100 + 32'(4 * i));
          for (int k = 0; k < 8; k++) begin
            bit g;
            g = (k == 0) ? (fv[0] && cv[0]) : (k == 1) ? (fv[1] && cv[1]) : 1'b1;
            e = (k < pw && g) ? seed + 32'(k) : 32'hA000_0000 + 32'(k);
            rd(4'(8 + k), v);
            chk((k < 2) ? "R7 addr reg" : "R6 cfg reg", v, e);
            if (k == 0) chk("R3 xfer src from load", xs[0], e);
          end
        end

    // R5 chain of three, pause flag with pause disabled (R8)
    wr(4'd0, C_LIST | C_FAST | 32'h30 | C_SRC | C_DST); wr(4'd1, 32'h40);
    put_desc(32'h40, 32'h80,   F_SRC | F_DST, 2, 32'h0000_1100);
    put_desc(32'h80, 32'hC0,   F_SRC | F_DST | F_PAUSE, 2, 32'h0000_2200);
    put_desc(32'hC0, END_PTR,  F_SRC | F_DST, 2, 32'h0000_3300);
    clear_logs(); mem_lat = 6; n0 = irq_cnt;
    pulse_start();
    @(posedge clk); #2;
    chk("R11 status fetching", 32'(status), 32'd1);
    wait_irq("R5", n0, nxa);
    chk("R5 irq only after last", nxa, 3);
    chk("R8 pause flag ignored", nx, 3);
    chk("R5 xfer1 src", xs[0], 32'h1100);
    chk("R5 xfer2 dst", xd[1], 32'h2201);
    chk("R5 xfer3 src", xs[2], 32'h3300);
    chk("R5 reads", nreads, 12);
    repeat (10) @(posedge clk); #2;
    chk("R5 single irq", irq_cnt, n0 + 1);
    mem_lat = 1;

    // R4 deferred first load, type 2
    for (int k = 0; k < 8; k++) wr(4'(8 + k), 32'hB000_0000 + 32'(k));
    wr(4'd0, C_LIST | 32'h20 | C_SRC | C_DST); wr(4'd1, 32'h100);
    put_desc(32'h100, 32'h140, F_SRC | F_DST, 4, 32'h6000_0000);
    put_desc(32'h140, END_PTR, F_SRC | F_DST, 4, 32'h7000_0000);
    clear_logs(); n0 = irq_cnt;
    pulse_start();
    wait_irq("R4", n0, nxa);
    chk("R4 transfers", nx, 3);
    chk("R4 first uses preset src", xs[0], 32'hB000_0000);
    chk("R4 first uses preset dst", xd[0], 32'hB000_0001);
    chk("R4 second src", xs[1], 32'h6000_0000);
    chk("R4 third dst", xd[2], 32'h7000_0001);
    chk("R4 first read addr", raddr[0], 32'h100);
    rd(4'd11, v); chk("R6 type2 reg3", v, 32'h7000_0003);
    rd(4'd12, v); chk("R6 type2 keeps reg4", v, 32'hB000_0004);

    // R8 pause, R9 start while busy, R10 writes while busy
    wr(4'd15, 32'h0000_7777);
    wr(4'd0, C_LIST | C_FAST | C_PEN | 32'h30 | C_SRC | C_DST); wr(4'd1, 32'h100);
    put_desc(32'h100, 32'h140, F_SRC | F_DST | F_PAUSE, 2, 32'h0000_8800);
    put_desc(32'h140, END_PTR, F_SRC | F_DST, 2, 32'h0000_9900);
    clear_logs(); n0 = irq_cnt;
    pulse_start();
    repeat (12) @(posedge clk); #2;
    chk("R8 paused status", 32'(status), 32'd3);
    repeat (20) @(posedge clk); #2;
    chk("R8 no transfer while paused", nx, 0);
    pulse_start();
    @(posedge clk); #2;
    chk("R9 start ignored when paused", 32'(status), 32'd3);
    wr(4'd0, 32'h0); wr(4'd15, 32'hDEAD_0000);
    rd(4'd0, v); chk("R10 ctrl write ignored", v, C_LIST | C_FAST | C_PEN | 32'h30 | C_SRC | C_DST);
    rd(4'd15, v); chk("R10 chan write ignored", v, 32'h0000_7777);
    chk("R8 still no transfer", nx, 0);
    pulse_resume();
    wait_irq("R8", n0, nxa);
    chk("R8 transfers after resume", nx, 2);
    chk("R8 paused descriptor src", xs[0], 32'h8800);
    pulse_resume();
    repeat (5) @(posedge clk); #2;
    chk("R8 resume ignored when done", 32'(status), 32'd4);
    chk("R8 resume no transfer", nx, 2);

    // R5 fast start with end pointer
    wr(4'd0, C_LIST | C_FAST); wr(4'd1, END_PTR);
    clear_logs(); n0 = irq_cnt;
    pulse_start();
    wait_irq("R5 empty", n0, nxa);
    chk("R5 empty no transfer", nx, 0);
    chk("R5 empty no reads", nreads, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule